// File: doc/BRIEF.md
# Variable-Refresh Vertical Line Counter

This block produces the vertical line position for a display timing generator whose frame length may vary from frame to frame. A line-rate strobe advances the count. A frame normally ends once the count reaches the programmed maximum line. When variable refresh is on, an external trigger can end the frame early, but never before the programmed minimum line. For a set number of frames, an optional middle limit can stand in for the maximum.

Frames longer than the counter can reach use a freeze point. When the count sits on the programmed stop line, a second counter absorbs a programmed number of extra strobes while the vertical count stays put. Counting then resumes. A trigger that arrives during the freeze still ends the frame. All configuration is captured into shadow copies at the start of each frame, so a write that lands mid-frame changes nothing until the next frame. Limits are programmed as the last line index, which is the line count minus one.

Top module: `vrr_vcount_gen`

## Requirements
- R1: While `rst` is high, and right after it is released, `vcount` and `hold_cnt` are 0 and `frame_start` and `vblank` are 0 (provided `cfg_vblank_start` is not 0).
- R2: Each cycle with `line_stb` high moves the frame forward by exactly one line. In a cycle without `line_stb`, `vcount` and `hold_cnt` keep their values.
- R3: With `cfg_vrr_en` low, every frame lasts `cfg_vmax`+1 strobes and `trig_in` has no effect.
- R4: With `cfg_vrr_en` high and no trigger, a frame lasts `cfg_vmax`+1 strobes.
- R5: With `cfg_vrr_en` high and bit 1 of `cfg_trig_mask` set, a `trig_in` pulse seen before the minimum is held pending. The frame then ends on the strobe taken at `vcount` = `cfg_vmin`, giving a length of `cfg_vmin`+1. Only one trigger is held; extra pulses in the same frame do not shorten the next frame.
- R6: When bit 1 of `cfg_trig_mask` is clear, `trig_in` is ignored even if bit 0 is set.
- R7: When `cfg_mid_en` goes from 0 to 1 at a frame start, the next `cfg_mid_frames` frames end at `cfg_vmid` instead of `cfg_vmax`. Later frames use `cfg_vmax` again.
- R8: On a strobe taken while `vcount` equals `cfg_stop_line` and `hold_cnt` is below `cfg_extra`, `hold_cnt` rises by one and `vcount` stays put. After `cfg_extra` such strobes, counting resumes. The frame is longer by `cfg_extra` lines.
- R9: A trigger accepted while the count is frozen ends the frame on the next strobe after it is latched.
- R10: `frame_start` is high for exactly the one cycle in which `vcount` has just returned to 0. In that cycle `hold_cnt` is 0.
- R11: `vblank` is high exactly while `vcount` is at or above `cfg_vblank_start`.
- R12: Configuration written during a frame takes effect only from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| line_stb | input | 1 | One-cycle strobe per line |
| trig_in | input | 1 | Early frame-end trigger |
| cfg_vrr_en | input | 1 | Enable minimum/maximum variable refresh |
| cfg_trig_mask | input | 2 | Trigger source mask; bit 1 enables `trig_in` |
| cfg_vmin | input | VW | Minimum last line (count minus one) |
| cfg_vmax | input | VW | Maximum last line (count minus one) |
| cfg_vmid | input | VW | Middle last line replacing the maximum |
| cfg_mid_en | input | 1 | Middle-limit enable |
| cfg_mid_frames | input | MFW | Number of frames that use the middle limit |
| cfg_stop_line | input | VW | Line at which counting freezes |
| cfg_extra | input | HW | Extra lines absorbed during the freeze |
| cfg_vblank_start | input | VW | First blanking line |
| vcount | output | VW | Vertical line position |
| hold_cnt | output | HW | Extra lines absorbed so far in this frame |
| frame_start | output | 1 | One-cycle pulse at the start of a frame |
| vblank | output | 1 | Vertical blanking flag |

## Verification
The main function is driven through several frame-length patterns. A fixed frame with the trigger held high shows that triggers are masked when variable refresh is off. A min/max frame with no trigger shows the maximum limit, and an early double trigger shows that the minimum clamps the frame and only one trigger is kept. A trigger masked by the wrong bit separates the mask bit position from the enable. The middle-limit pattern shows that the replacement is counted per frame. Two long-frame patterns, one with no trigger and one with a trigger during the freeze, separate the freeze length from the early exit. A sparse strobe rate, the lengths of the frames in which new settings are written, and a line-by-line comparison against a behavioural model cover idle cycles and shadow timing.

// File: rtl/vrr_pkg.sv
package vrr_pkg;
  localparam int DEF_VW  = 8;
  localparam int DEF_HW  = 8;
  localparam int DEF_MFW = 4;

  typedef enum logic [1:0] {
    END_NONE    = 2'd0,
    END_NATURAL = 2'd1,
    END_TRIGGER = 2'd2
  } vrr_end_e;
endpackage

// File: rtl/vrr_shadow_regs.sv
module vrr_shadow_regs #(
  parameter int VW  = 8,
  parameter int HW  = 8,
  parameter int MFW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           i_vrr_en,
  input  logic [1:0]     i_trig_mask,
  input  logic [VW-1:0]  i_vmin,
  input  logic [VW-1:0]  i_vmax,
  input  logic [VW-1:0]  i_vmid,
  input  logic           i_mid_en,
  input  logic [MFW-1:0] i_mid_frames,
  input  logic [VW-1:0]  i_stop_line,
  input  logic [HW-1:0]  i_extra,
  input  logic [VW-1:0]  i_vbs,
  output logic           s_vrr_en,
  output logic [1:0]     s_trig_mask,
  output logic [VW-1:0]  s_vmin,
  output logic [VW-1:0]  s_vmax,
  output logic [VW-1:0]  s_vmid,
  output logic           s_mid_en,
  output logic [MFW-1:0] s_mid_frames,
  output logic [VW-1:0]  s_stop_line,
  output logic [HW-1:0]  s_extra,
  output logic [VW-1:0]  s_vbs
);
  // Capture during reset and at each frame boundary.
  always_ff @(posedge clk) begin
    if (rst || load) begin
      s_vrr_en     <= i_vrr_en;
      s_trig_mask  <= i_trig_mask;
      s_vmin       <= i_vmin;
      s_vmax       <= i_vmax;
      s_vmid       <= i_vmid;
      s_mid_en     <= i_mid_en;
      s_mid_frames <= i_mid_frames;
      s_stop_line  <= i_stop_line;
      s_extra      <= i_extra;
      s_vbs        <= i_vbs;
    end
  end
endmodule

// File: rtl/vrr_trig_latch.sv
module vrr_trig_latch #(
  parameter int MASK_W   = 2,
  parameter int TRIG_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_in,
  input  logic              vrr_en,
  input  logic [MASK_W-1:0] mask,
  input  logic              clr,
  output logic              pend
);
  localparam logic [MASK_W-1:0] SEL = MASK_W'(1) << TRIG_BIT;

  logic trig_ok;
  assign trig_ok = trig_in && vrr_en && (|(mask & SEL));

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (trig_ok) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end

  // R5
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !trig_ok) |=> !pend);
endmodule

// File: rtl/vrr_line_engine.sv
module vrr_line_engine
  import vrr_pkg::*;
#(
  parameter int VW  = 8,
  parameter int HW  = 8,
  parameter int MFW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_stb,
  input  logic           pend,
  input  logic           s_vrr_en,
  input  logic [VW-1:0]  s_vmin,
  input  logic [VW-1:0]  s_vmax,
  input  logic [VW-1:0]  s_vmid,
  input  logic           s_mid_en,
  input  logic [VW-1:0]  s_stop_line,
  input  logic [HW-1:0]  s_extra,
  input  logic [VW-1:0]  s_vbs,
  input  logic           n_mid_en,
  input  logic [MFW-1:0] n_mid_frames,
  input  logic [VW-1:0]  n_vbs,
  output logic           frame_end,
  output logic [VW-1:0]  vcount_q,
  output logic [HW-1:0]  hold_q,
  output logic           frame_start_q,
  output logic           vblank_q
);
  logic [MFW-1:0] mid_left_q;
  logic           holding, trig_end, nat_end;
  logic [VW-1:0]  lim;
  logic [VW-1:0]  vc_nxt, vbs_nxt;
  vrr_end_e       end_kind;

  assign holding  = (vcount_q == s_stop_line) && (hold_q != s_extra);
  assign lim      = (s_mid_en && (mid_left_q != '0)) ? s_vmid : s_vmax;
  assign trig_end = s_vrr_en && pend && (vcount_q >= s_vmin);
  assign nat_end  = !holding && (vcount_q >= lim);

  always_comb begin
    end_kind = END_NONE;
    if (line_stb) begin
      if (trig_end)     end_kind = END_TRIGGER;
      else if (nat_end) end_kind = END_NATURAL;
    end
  end

  assign frame_end = (end_kind != END_NONE);
  assign vc_nxt    = frame_end ? '0 :
                     (line_stb && !holding) ? vcount_q + 1'b1 : vcount_q;
  assign vbs_nxt   = frame_end ? n_vbs : s_vbs;

  always_ff @(posedge clk) begin
    if (rst) begin
      vcount_q      <= '0;
      hold_q        <= '0;
      frame_start_q <= 1'b0;
      vblank_q      <= 1'b0;
      mid_left_q    <= n_mid_en ? n_mid_frames : '0;
    end else begin
      vcount_q      <= vc_nxt;
      frame_start_q <= frame_end;
      vblank_q      <= (vc_nxt >= vbs_nxt);
      if (frame_end)                hold_q <= '0;
      else if (line_stb && holding) hold_q <= hold_q + 1'b1;
      if (frame_end) begin
        if (n_mid_en && !s_mid_en)    mid_left_q <= n_mid_frames;
        else if (mid_left_q != '0)    mid_left_q <= mid_left_q - 1'b1;
      end
    end
  end

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !line_stb |=> ($stable(vcount_q) && $stable(hold_q)));
  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (line_stb && holding && !frame_end) |=>
      ($stable(vcount_q) && hold_q == $past(hold_q) + 1'b1));
  // R8
  hold_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q <= s_extra);
  // R10
  fs_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start_q |-> (vcount_q == '0 && hold_q == '0));
endmodule

// File: rtl/vrr_vcount_gen.sv
module vrr_vcount_gen
  import vrr_pkg::*;
#(
  parameter int VW  = DEF_VW,
  parameter int HW  = DEF_HW,
  parameter int MFW = DEF_MFW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_stb,
  input  logic           trig_in,
  input  logic           cfg_vrr_en,
  input  logic [1:0]     cfg_trig_mask,
  input  logic [VW-1:0]  cfg_vmin,
  input  logic [VW-1:0]  cfg_vmax,
  input  logic [VW-1:0]  cfg_vmid,
  input  logic           cfg_mid_en,
  input  logic [MFW-1:0] cfg_mid_frames,
  input  logic [VW-1:0]  cfg_stop_line,
  input  logic [HW-1:0]  cfg_extra,
  input  logic [VW-1:0]  cfg_vblank_start,
  output logic [VW-1:0]  vcount,
  output logic [HW-1:0]  hold_cnt,
  output logic           frame_start,
  output logic           vblank
);
  logic           s_vrr_en, s_mid_en, pend, frame_end;
  logic [1:0]     s_trig_mask;
  logic [VW-1:0]  s_vmin, s_vmax, s_vmid, s_stop_line, s_vbs;
  logic [HW-1:0]  s_extra;
  logic [MFW-1:0] s_mid_frames;

  vrr_shadow_regs #(.VW(VW), .HW(HW), .MFW(MFW)) u_shadow (
    .clk(clk), .rst(rst), .load(frame_end),
    .i_vrr_en(cfg_vrr_en), .i_trig_mask(cfg_trig_mask),
    .i_vmin(cfg_vmin), .i_vmax(cfg_vmax), .i_vmid(cfg_vmid),
    .i_mid_en(cfg_mid_en), .i_mid_frames(cfg_mid_frames),
    .i_stop_line(cfg_stop_line), .i_extra(cfg_extra), .i_vbs(cfg_vblank_start),
    .s_vrr_en(s_vrr_en), .s_trig_mask(s_trig_mask),
    .s_vmin(s_vmin), .s_vmax(s_vmax), .s_vmid(s_vmid),
    .s_mid_en(s_mid_en), .s_mid_frames(s_mid_frames),
    .s_stop_line(s_stop_line), .s_extra(s_extra), .s_vbs(s_vbs)
  );

  vrr_trig_latch #(.MASK_W(2), .TRIG_BIT(1)) u_trig (
    .clk(clk), .rst(rst), .trig_in(trig_in), .vrr_en(s_vrr_en),
    .mask(s_trig_mask), .clr(frame_end), .pend(pend)
  );

  vrr_line_engine #(.VW(VW), .HW(HW), .MFW(MFW)) u_engine (
    .clk(clk), .rst(rst), .line_stb(line_stb), .pend(pend),
    .s_vrr_en(s_vrr_en), .s_vmin(s_vmin), .s_vmax(s_vmax), .s_vmid(s_vmid),
    .s_mid_en(s_mid_en), .s_stop_line(s_stop_line), .s_extra(s_extra),
    .s_vbs(s_vbs), .n_mid_en(cfg_mid_en), .n_mid_frames(cfg_mid_frames),
    .n_vbs(cfg_vblank_start), .frame_end(frame_end),
    .vcount_q(vcount), .hold_q(hold_cnt),
    .frame_start_q(frame_start), .vblank_q(vblank)
  );

  // The shadow copy of the middle-frame count is captured for symmetry but
  // the engine loads its countdown from the incoming value at the boundary.
  logic unused_ok;
  assign unused_ok = ^s_mid_frames;

  // R11
  vblank_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && $past(!frame_start)) |-> (vblank == (vcount >= s_vbs)));
endmodule

// File: tb/vrr_vcount_gen_bench.sv
module vrr_vcount_gen_bench;
  localparam int VW = 8, HW = 8, MFW = 4;

  logic clk = 1'b0, rst = 1'b1, line_stb = 1'b0, trig_in = 1'b0;
  logic cfg_vrr_en = 1'b0, cfg_mid_en = 1'b0;
  logic [1:0] cfg_trig_mask = 2'b00;
  logic [VW-1:0] cfg_vmin = 0, cfg_vmax = 9, cfg_vmid = 0, cfg_stop_line = 0, cfg_vblank_start = 7;
  logic [MFW-1:0] cfg_mid_frames = 0;
  logic [HW-1:0] cfg_extra = 0;
  logic [VW-1:0] vcount;
  logic [HW-1:0] hold_cnt;
  logic frame_start, vblank;

  vrr_vcount_gen #(.VW(VW), .HW(HW), .MFW(MFW)) u_vrr_vcount_gen (
    .clk(clk), .rst(rst), .line_stb(line_stb), .trig_in(trig_in),
    .cfg_vrr_en(cfg_vrr_en), .cfg_trig_mask(cfg_trig_mask),
    .cfg_vmin(cfg_vmin), .cfg_vmax(cfg_vmax), .cfg_vmid(cfg_vmid),
    .cfg_mid_en(cfg_mid_en), .cfg_mid_frames(cfg_mid_frames),
    .cfg_stop_line(cfg_stop_line), .cfg_extra(cfg_extra),
    .cfg_vblank_start(cfg_vblank_start), .vcount(vcount), .hold_cnt(hold_cnt),
    .frame_start(frame_start), .vblank(vblank)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int stb_period = 1, stb_cnt = 0;
  int total_stb = 0, last_mark = 0;
  int lens[$];

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Line strobe generator.
  always @(negedge clk) begin
    if (stb_cnt >= stb_period - 1) begin line_stb <= 1'b1; stb_cnt <= 0; end
    else begin line_stb <= 1'b0; stb_cnt <= stb_cnt + 1; end
  end

  // Behavioural reference model.
  int m_vc, m_hold, m_left, m_pend, m_fs, m_vb;
  int s_mm, s_mask, s_vmin, s_vmax, s_vmid, s_miden, s_stop, s_extra, s_vbs;
  always @(posedge clk) begin
    if (rst) begin
      s_mm = cfg_vrr_en; s_mask = cfg_trig_mask; s_vmin = cfg_vmin; s_vmax = cfg_vmax;
      s_vmid = cfg_vmid; s_miden = cfg_mid_en; s_stop = cfg_stop_line;
      s_extra = cfg_extra; s_vbs = cfg_vblank_start;
      m_left = cfg_mid_en ? cfg_mid_frames : 0;
      m_vc = 0; m_hold = 0; m_pend = 0; m_fs = 0; m_vb = 0;
      total_stb = 0;
    end else begin
      bit frozen, ends, acc;
      int lim;
      if (line_stb) total_stb = total_stb + 1;
      frozen = (m_vc == s_stop) && (m_hold < s_extra);
      lim = (s_miden != 0 && m_left > 0) ? s_vmid : s_vmax;
      ends = line_stb && ((s_mm != 0 && m_pend != 0 && m_vc >= s_vmin) || (!frozen && m_vc >= lim));
      acc = trig_in && s_mm != 0 && s_mask[1];
      if (acc) m_pend = 1; else if (ends) m_pend = 0;
      if (ends) begin
        m_vc = 0; m_hold = 0;
        if (cfg_mid_en && s_miden == 0) m_left = cfg_mid_frames;
        else if (m_left > 0) m_left = m_left - 1;
        s_mm = cfg_vrr_en; s_mask = cfg_trig_mask; s_vmin = cfg_vmin; s_vmax = cfg_vmax;
        s_vmid = cfg_vmid; s_miden = cfg_mid_en; s_stop = cfg_stop_line;
        s_extra = cfg_extra; s_vbs = cfg_vblank_start;
      end else if (line_stb) begin
        if (frozen) m_hold = m_hold + 1; else m_vc = m_vc + 1;
      end
      m_fs = ends;
      m_vb = (m_vc >= s_vbs);
    end
  end

  // Per-cycle comparison and frame length recording.
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_req, "model vcount", vcount, m_vc);
      chk(cur_req, "model hold_cnt", hold_cnt, m_hold);
      chk("R10", "model frame_start", frame_start, m_fs);
      chk("R11", "model vblank", vblank, m_vb);
      if (frame_start) begin
        lens.push_back(total_stb - last_mark);
        last_mark = total_stb;
      end
    end
  end

  task automatic wait_frames(int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk); #2;
      if (frame_start) k++;
    end
  endtask

  task automatic pulse_trig();
    trig_in = 1'b1;
    @(negedge clk); #2;
    trig_in = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset vcount", vcount, 0);
    chk("R1", "reset hold_cnt", hold_cnt, 0);
    chk("R1", "reset frame_start", frame_start, 0);
    chk("R1", "reset vblank", vblank, 0);
    rst = 1'b0;
    @(negedge clk); #2;
    chk("R1", "post-reset vcount", vcount, 1);

    // Fixed timing, trigger held high.
    cur_req = "R3";
    trig_in = 1'b1;
    wait_frames(3);
    trig_in = 1'b0;
    for (int i = 0; i < 3; i++) chk("R3", "fixed frame length", lens[i], 10);

    // Min/max enabled, sparse strobes, no trigger; write lands mid-frame.
    cur_req = "R2";
    stb_period = 3;
    repeat (4) @(negedge clk);
    #2;
    cfg_vrr_en = 1'b1; cfg_vmin = 4; cfg_vmax = 11; cfg_trig_mask = 2'b10;
    lens.delete();
    wait_frames(3);
    chk("R12", "frame with mid-frame write keeps old length", lens[0], 10);
    chk("R4", "max frame length", lens[1], 12);
    chk("R4", "max frame length", lens[2], 12);

    // Early double trigger.
    cur_req = "R5";
    stb_period = 1;
    lens.delete();
    @(negedge clk); #2;
    pulse_trig();
    @(negedge clk); #2;
    pulse_trig();
    wait_frames(2);
    chk("R5", "triggered frame clamped at min", lens[0], 5);
    chk("R5", "second trigger not carried over", lens[1], 12);

    // Mask bit 0 only.
    cur_req = "R6";
    cfg_trig_mask = 2'b01;
    wait_frames(1);
    lens.delete();
    pulse_trig();
    wait_frames(1);
    chk("R6", "masked trigger ignored", lens[0], 12);

    // Middle limit for two frames.
    cur_req = "R7";
    cfg_trig_mask = 2'b10; cfg_vmid = 6; cfg_mid_en = 1'b1; cfg_mid_frames = 2;
    lens.delete();
    wait_frames(5);
    chk("R7", "old frame", lens[0], 12);
    chk("R7", "mid frame 1", lens[1], 7);
    chk("R7", "mid frame 2", lens[2], 7);
    chk("R7", "max restored", lens[3], 12);
    chk("R7", "max restored", lens[4], 12);

    // Fixed long frame with freeze.
    cur_req = "R8";
    cfg_mid_en = 1'b0; cfg_vmin = 20; cfg_vmax = 20; cfg_stop_line = 5;
    cfg_extra = 7; cfg_vblank_start = 15;
    wait_frames(1);
    lens.delete();
    begin
      int hmax = 0;
      do begin
        @(negedge clk); #2;
        if (hold_cnt > hmax) hmax = hold_cnt;
        if (vcount == 14) chk("R11", "vblank below start", vblank, 0);
        if (vcount == 15) chk("R11", "vblank at start", vblank, 1);
      end while (!frame_start);
      chk("R8", "extra lines absorbed", hmax, 7);
    end
    chk("R8", "long frame length", lens[0], 28);

    // Variable long frame, trigger during freeze.
    cur_req = "R9";
    cfg_vmin = 5; cfg_extra = 10;
    wait_frames(1);
    lens.delete();
    do begin @(negedge clk); #2; end while (hold_cnt != 3);
    chk("R9", "count frozen at stop line", vcount, 5);
    pulse_trig();
    wait_frames(1);
    chk("R9", "trigger ends frozen frame", lens[0], 10);
    wait_frames(1);
    chk("R8", "untriggered variable long frame", lens[1], 31);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule